// File: doc/BRIEF.md
# RV32I Single-Cycle Control Decoder

This block is the purely combinational controller of a single-cycle RV32I core. In the same cycle it turns the current 32-bit instruction word into every steering and enable signal the datapath needs. Those signals cover:

- next-PC choice
- immediate format
- register write enable
- signed/unsigned compare mode
- ALU operand sources
- ALU operation
- data-memory write enable
- write-back source

Conditional branches are resolved from two flags, equal and less-than, which an external comparator produces from the two source registers. The decoder only picks between the branch target and PC+4.

ECALL is not a trap here. It raises a halt request, which the surrounding core uses to freeze its program counter on that instruction for good. The halt request is also used to hand the data-memory address port to an external debug reader.

Loads and stores are word-wide only, because the control word carries no access-size field. Any word the decoder does not recognise produces an all-zero control word. An all-zero word changes no architectural state.

Top module: `rvdec_ctrl`

## Requirements
- R1: Register-register instructions (opcode 0110011) give reg_wen=1, a_sel=0 (register), b_sel=0 (register), wb_sel=1 (ALU). alu_sel follows funct3 using this encoding: ADD=0, SUB=1, SLL=2, SLT=3, SLTU=4, XOR=5, SRL=6, SRA=7, OR=8, AND=9, PASS_B=10. Instruction bit 30 selects SUB over ADD and SRA over SRL. funct7 must be 0000000, or 0100000 for funct3 000/101 only.
- R2: Register-immediate instructions (opcode 0010011) give imm_sel=0 (I) and b_sel=1 (immediate), with reg_wen=1 and wb_sel=1. Bit 30 selects SRAI over SRLI. For ADDI bit 30 is immediate data and the ALU stays ADD. Shift-immediates need funct7 0000000, or 0100000 for the right shift only.
- R3: LW (opcode 0000011, funct3 010) gives imm_sel=0, b_sel=1, alu_sel=ADD, reg_wen=1, wb_sel=0 (memory). SW (opcode 0100011, funct3 010) gives imm_sel=1 (S), b_sel=1, alu_sel=ADD, mem_we=1, reg_wen=0.
- R4: Branches (opcode 1100011) give imm_sel=2 (B), a_sel=1 (PC), b_sel=1, alu_sel=ADD, with no register or memory write.
  - pc_sel=1 (target) when taken and 0 (PC+4) otherwise.
  - BEQ (000) is taken on eq and BNE (001) on !eq.
  - BLT (100) and BLTU (110) are taken on lt.
  - BGE (101) and BGEU (111) are taken on !lt.
  - br_un=1 only for BLTU and BGEU.
- R5: JAL (opcode 1101111) gives imm_sel=4 (J) and a_sel=1. JALR (opcode 1100111, funct3 000) gives imm_sel=0 and a_sel=0. Both always give pc_sel=1, b_sel=1, alu_sel=ADD, reg_wen=1, wb_sel=2 (PC+4) and mem_we=0.
- R6: LUI (opcode 0110111) gives imm_sel=3 (U), b_sel=1, alu_sel=PASS_B, reg_wen=1, wb_sel=1. AUIPC (opcode 0010111) is the same except a_sel=1 and alu_sel=ADD.
- R7: The exact word 0x00000073 (ECALL) gives halt=1 with every other output 0. No other word raises halt.
- R8: An unknown opcode, an illegal funct3/funct7 combination or any other SYSTEM word drives every output to 0. That means pc_sel=0 (PC+4), reg_wen=0 and mem_we=0.
- R9: For every non-branch instruction the br_eq and br_lt inputs have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Current instruction word |
| br_eq | input | 1 | Comparator flag: operands equal |
| br_lt | input | 1 | Comparator flag: rs1 less than rs2 |
| halt | output | 1 | Halt request (ECALL) |
| pc_sel | output | 1 | 0 = PC+4, 1 = ALU target |
| imm_sel | output | 3 | Immediate format: I=0, S=1, B=2, U=3, J=4 |
| reg_wen | output | 1 | Register file write enable |
| br_un | output | 1 | Comparator unsigned mode |
| a_sel | output | 1 | ALU operand A: 0 = rs1, 1 = PC |
| b_sel | output | 1 | ALU operand B: 0 = rs2, 1 = immediate |
| alu_sel | output | 4 | ALU operation code |
| mem_we | output | 1 | Data memory write enable |
| wb_sel | output | 2 | Write-back: 0 = memory, 1 = ALU, 2 = PC+4 |

## Verification
The decoder holds no state, so any misclassification shows up at the ports in the same cycle the word is applied. There is no hidden condition that surfaces later. A wrong class decision shows as a whole control word that differs from the expected one. A wrong branch polarity or compare mode shows only under particular flag pairs, so every instruction is applied with all four eq/lt combinations. Illegal function fields and stray SYSTEM words are placed right next to legal ones, so that an over-permissive legality check shows as a non-zero enable.

// File: rtl/rvdec_pkg.sv
package rvdec_pkg;
  localparam int ILEN   = 32;
  localparam int OPC_W  = 7;
  localparam int F3_W   = 3;
  localparam int F7_W   = 7;
  localparam int IMM_W  = 3;
  localparam int ALU_W  = 4;
  localparam int WB_W   = 2;

  localparam logic [OPC_W-1:0] OPC_OP     = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;
  localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;
  localparam logic [OPC_W-1:0] OPC_LUI    = 7'b0110111;
  localparam logic [OPC_W-1:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [ILEN-1:0]  WORD_ECALL = 32'h0000_0073;
  localparam logic [F7_W-1:0]  F7_BASE    = 7'b0000000;
  localparam logic [F7_W-1:0]  F7_ALT     = 7'b0100000;

  typedef enum logic [IMM_W-1:0] {
    IMM_I = 3'd0, IMM_S = 3'd1, IMM_B = 3'd2, IMM_U = 3'd3, IMM_J = 3'd4
  } imm_kind_e;

  typedef enum logic [ALU_W-1:0] {
    ALU_ADD = 4'd0, ALU_SUB = 4'd1, ALU_SLL = 4'd2, ALU_SLT = 4'd3,
    ALU_SLTU = 4'd4, ALU_XOR = 4'd5, ALU_SRL = 4'd6, ALU_SRA = 4'd7,
    ALU_OR = 4'd8, ALU_AND = 4'd9, ALU_PASSB = 4'd10
  } alu_op_e;

  typedef enum logic [WB_W-1:0] {
    WB_MEM = 2'd0, WB_ALU = 2'd1, WB_PC4 = 2'd2
  } wb_src_e;

  typedef enum logic [3:0] {
    CL_NONE, CL_OP, CL_OPIMM, CL_LOAD, CL_STORE, CL_BRANCH,
    CL_JAL, CL_JALR, CL_LUI, CL_AUIPC, CL_ECALL
  } iclass_e;

  typedef struct packed {
    logic      halt;
    logic      pc_sel;
    imm_kind_e imm;
    logic      reg_wen;
    logic      br_un;
    logic      a_sel;
    logic      b_sel;
    alu_op_e   alu;
    logic      mem_we;
    wb_src_e   wb;
  } ctrl_t;

  // funct3 to ALU operation; alt applies the bit-30 variant where allowed
  function automatic alu_op_e alu_of_funct(input logic [F3_W-1:0] f3, input logic alt);
    case (f3)
      3'b000:  return alt ? ALU_SUB : ALU_ADD;
      3'b001:  return ALU_SLL;
      3'b010:  return ALU_SLT;
      3'b011:  return ALU_SLTU;
      3'b100:  return ALU_XOR;
      3'b101:  return alt ? ALU_SRA : ALU_SRL;
      3'b110:  return ALU_OR;
      default: return ALU_AND;
    endcase
  endfunction
endpackage

// File: rtl/rvdec_fields.sv
module rvdec_fields
  import rvdec_pkg::*;
(
  input  logic [ILEN-1:0] instr,
  output iclass_e         cls,
  output logic [F3_W-1:0] funct3,
  output logic            alt_bit
);
  logic [OPC_W-1:0] opc;
  logic [F7_W-1:0]  f7;
  logic             f7_base, f7_alt, f3_word, shift_f3;

  assign opc      = instr[6:0];
  assign funct3   = instr[14:12];
  assign f7       = instr[31:25];
  assign alt_bit  = instr[30];
  assign f7_base  = (f7 == F7_BASE);
  assign f7_alt   = (f7 == F7_ALT);
  assign f3_word  = (funct3 == 3'b010);
  assign shift_f3 = (funct3 == 3'b001) || (funct3 == 3'b101);

  always_comb begin
    cls = CL_NONE;
    case (opc)
      OPC_OP:     if (f7_base || (f7_alt && (funct3 == 3'b000 || funct3 == 3'b101))) cls = CL_OP;
      OPC_OPIMM:  if (!shift_f3 || f7_base || (f7_alt && funct3 == 3'b101)) cls = CL_OPIMM;
      OPC_LOAD:   if (f3_word) cls = CL_LOAD;
      OPC_STORE:  if (f3_word) cls = CL_STORE;
      OPC_BRANCH: if (funct3[2:1] != 2'b01) cls = CL_BRANCH;
      OPC_JAL:    cls = CL_JAL;
      OPC_JALR:   if (funct3 == 3'b000) cls = CL_JALR;
      OPC_LUI:    cls = CL_LUI;
      OPC_AUIPC:  cls = CL_AUIPC;
      default:    if (instr == WORD_ECALL) cls = CL_ECALL;
    endcase
  end
endmodule

// File: rtl/rvdec_branch.sv
module rvdec_branch
  import rvdec_pkg::*;
(
  input  logic [F3_W-1:0] funct3,
  input  logic            is_branch,
  input  logic            br_eq,
  input  logic            br_lt,
  output logic            take,
  output logic            unsigned_cmp
);
  logic flag, cond;
  // funct3[2] picks the less-than flag, funct3[0] inverts the sense
  assign flag         = funct3[2] ? br_lt : br_eq;
  assign cond         = flag ^ funct3[0];
  assign take         = is_branch && cond;
  assign unsigned_cmp = is_branch && funct3[2] && funct3[1];
endmodule

// File: rtl/rvdec_ctrl.sv
module rvdec_ctrl
  import rvdec_pkg::*;
(
  input  logic [31:0] instr,
  input  logic        br_eq,
  input  logic        br_lt,
  output logic        halt,
  output logic        pc_sel,
  output logic [2:0]  imm_sel,
  output logic        reg_wen,
  output logic        br_un,
  output logic        a_sel,
  output logic        b_sel,
  output logic [3:0]  alu_sel,
  output logic        mem_we,
  output logic [1:0]  wb_sel
);
  iclass_e         cls;
  logic [F3_W-1:0] funct3;
  logic            alt_bit;
  logic            br_take, br_unsigned, is_branch, is_jump;
  ctrl_t           c;

  rvdec_fields u_fields (.instr(instr), .cls(cls), .funct3(funct3), .alt_bit(alt_bit));

  assign is_branch = (cls == CL_BRANCH);
  assign is_jump   = (cls == CL_JAL) || (cls == CL_JALR);

  rvdec_branch u_branch (
    .funct3(funct3), .is_branch(is_branch), .br_eq(br_eq), .br_lt(br_lt),
    .take(br_take), .unsigned_cmp(br_unsigned)
  );

  always_comb begin
    c = '0;
    case (cls)
      CL_OP: begin
        c.reg_wen = 1'b1; c.wb = WB_ALU; c.alu = alu_of_funct(funct3, alt_bit);
      end
      CL_OPIMM: begin
        c.reg_wen = 1'b1; c.wb = WB_ALU; c.imm = IMM_I; c.b_sel = 1'b1;
        c.alu = alu_of_funct(funct3, alt_bit && (funct3 == 3'b101));
      end
      CL_LOAD: begin
        c.reg_wen = 1'b1; c.wb = WB_MEM; c.imm = IMM_I; c.b_sel = 1'b1; c.alu = ALU_ADD;
      end
      CL_STORE: begin
        c.mem_we = 1'b1; c.imm = IMM_S; c.b_sel = 1'b1; c.alu = ALU_ADD;
      end
      CL_BRANCH: begin
        c.imm = IMM_B; c.a_sel = 1'b1; c.b_sel = 1'b1; c.alu = ALU_ADD;
        c.pc_sel = br_take; c.br_un = br_unsigned;
      end
      CL_JAL: begin
        c.imm = IMM_J; c.a_sel = 1'b1; c.b_sel = 1'b1; c.alu = ALU_ADD;
        c.pc_sel = 1'b1; c.reg_wen = 1'b1; c.wb = WB_PC4;
      end
      CL_JALR: begin
        c.imm = IMM_I; c.b_sel = 1'b1; c.alu = ALU_ADD;
        c.pc_sel = 1'b1; c.reg_wen = 1'b1; c.wb = WB_PC4;
      end
      CL_LUI: begin
        c.imm = IMM_U; c.b_sel = 1'b1; c.alu = ALU_PASSB; c.reg_wen = 1'b1; c.wb = WB_ALU;
      end
      CL_AUIPC: begin
        c.imm = IMM_U; c.a_sel = 1'b1; c.b_sel = 1'b1; c.alu = ALU_ADD;
        c.reg_wen = 1'b1; c.wb = WB_ALU;
      end
      CL_ECALL: c.halt = 1'b1;
      default: c = '0;
    endcase
  end

  assign halt    = c.halt;
  assign pc_sel  = c.pc_sel;
  assign imm_sel = c.imm;
  assign reg_wen = c.reg_wen;
  assign br_un   = c.br_un;
  assign a_sel   = c.a_sel;
  assign b_sel   = c.b_sel;
  assign alu_sel = c.alu;
  assign mem_we  = c.mem_we;
  assign wb_sel  = c.wb;

  always_comb begin
    AST_HALT_IS_ECALL: assert (!halt || instr == WORD_ECALL) else $error("halt without ECALL"); // R7
    AST_HALT_FREEZES: assert (!halt || (!reg_wen && !mem_we && !pc_sel)) else $error("halt with state change"); // R7
    AST_STORE_NO_RD: assert (!mem_we || (!reg_wen && imm_sel == IMM_S)) else $error("store writes rd"); // R3
    AST_BRUN_BRANCH_ONLY: assert (!br_un || (is_branch && instr[14:13] == 2'b11)) else $error("br_un outside BLTU/BGEU"); // R4
    AST_JUMP_LINKS: assert (!is_jump || (pc_sel && reg_wen && wb_sel == WB_PC4 && !mem_we)) else $error("jump control wrong"); // R5
    AST_UNKNOWN_QUIET: assert (cls != CL_NONE || (!reg_wen && !mem_we && !pc_sel && !halt)) else $error("illegal word acts"); // R8
    AST_FLAGS_GATED: assert (is_branch || !br_un) else $error("branch-only output outside branch"); // R9
  end
endmodule

// File: tb/tb_rvdec_ctrl.sv
module tb_rvdec_ctrl;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] instr = 32'h0;
  logic br_eq = 1'b0, br_lt = 1'b0;
  logic halt, pc_sel, reg_wen, br_un, a_sel, b_sel, mem_we;
  logic [2:0] imm_sel;
  logic [3:0] alu_sel;
  logic [1:0] wb_sel;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  rvdec_ctrl dut (.instr(instr), .br_eq(br_eq), .br_lt(br_lt), .halt(halt), .pc_sel(pc_sel),
    .imm_sel(imm_sel), .reg_wen(reg_wen), .br_un(br_un), .a_sel(a_sel), .b_sel(b_sel),
    .alu_sel(alu_sel), .mem_we(mem_we), .wb_sel(wb_sel));

  // observed word: wb, mem, alu, b, a, un, rw, imm, pc, halt (own order)
  function automatic logic [15:0] pack(input logic h, p, input logic [2:0] im, input logic rw, un, a, b,
                                       input logic [3:0] al, input logic mw, input logic [1:0] wb);
    return {wb, mw, al, b, a, un, rw, im, p, h};
  endfunction

  // behavioural expectation, built from the requirements
  function automatic logic [15:0] model(input logic [31:0] w, input logic eq, input logic lt);
    int op = w[6:0], f3 = w[14:12], f7 = w[31:25];
    int amap[8] = '{0, 2, 3, 4, 5, 6, 8, 9};
    bit shift = (f3 == 1 || f3 == 5);
    bit taken;
    if (op == 'h33 && (f7 == 0 || (f7 == 'h20 && (f3 == 0 || f3 == 5))))
      return pack(0, 0, 0, 1, 0, 0, 0, 4'(amap[f3] + (f7 == 'h20 ? 1 : 0)), 0, 1);
    if (op == 'h13 && (!shift || f7 == 0 || (f7 == 'h20 && f3 == 5)))
      return pack(0, 0, 0, 1, 0, 0, 1, 4'(amap[f3] + ((f3 == 5 && f7 == 'h20) ? 1 : 0)), 0, 1);
    if (op == 'h03 && f3 == 2) return pack(0, 0, 0, 1, 0, 0, 1, 0, 0, 0);
    if (op == 'h23 && f3 == 2) return pack(0, 0, 1, 0, 0, 0, 1, 0, 1, 0);
    if (op == 'h63 && f3 != 2 && f3 != 3) begin
      case (f3)
        0: taken = eq;
        1: taken = !eq;
        4, 6: taken = lt;
        default: taken = !lt;
      endcase
      return pack(0, taken, 2, 0, (f3 >= 6), 1, 1, 0, 0, 0);
    end
    if (op == 'h6f) return pack(0, 1, 4, 1, 0, 1, 1, 0, 0, 2);
    if (op == 'h67 && f3 == 0) return pack(0, 1, 0, 1, 0, 0, 1, 0, 0, 2);
    if (op == 'h37) return pack(0, 0, 3, 1, 0, 0, 1, 10, 0, 1);
    if (op == 'h17) return pack(0, 0, 3, 1, 0, 1, 1, 0, 0, 1);
    if (w == 32'h73) return pack(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    return 16'h0;
  endfunction

  function automatic logic [31:0] mk(input int f7, input int f3, input int op, input int rs = 5);
    return {7'(f7), 5'(rs), 5'd6, 3'(f3), 5'd7, 7'(op)};
  endfunction

  task automatic check(input logic [31:0] w, input logic eq, input logic lt, input string req);
    logic [15:0] got, exp;
    @(negedge clk);
    instr = w; br_eq = eq; br_lt = lt;
    #1;
    got = pack(halt, pc_sel, imm_sel, reg_wen, br_un, a_sel, b_sel, alu_sel, mem_we, wb_sel);
    exp = model(w, eq, lt);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s instr=%08h eq=%0b lt=%0b got=%04h exp=%04h", req, w, eq, lt, got, exp);
    end
  endtask

  task automatic all_flags(input logic [31:0] w, input string req);
    for (int k = 0; k < 4; k++) check(w, k[1], k[0], req);
  endtask

  initial begin
    // idle word 0 is an unknown opcode: all outputs low
    check(32'h0, 0, 0, "R8 idle");
    for (int f = 0; f < 8; f++) begin
      all_flags(mk(0, f, 'h33), "R1 base");
      all_flags(mk('h20, f, 'h33), "R1 alt");
      all_flags(mk(0, f, 'h13), "R2 base");
      all_flags(mk('h20, f, 'h13), "R2 alt/addi");
      all_flags(mk('h01, f, 'h33), "R8 bad funct7");
      all_flags(mk(0, f, 'h63), "R4 branch");
      all_flags(mk('h7f, f, 'h03), "R3 load/R8");
      all_flags(mk(0, f, 'h23), "R3 store/R8");
      all_flags(mk(3, f, 'h67), "R5 jalr/R8");
    end
    all_flags(32'h123450ef, "R5 jal");
    all_flags(32'hfffff0b7, "R6 lui");
    all_flags(32'h00001097, "R6 auipc");
    all_flags(32'h00000073, "R7 ecall");
    all_flags(32'h00100073, "R8 ebreak");
    all_flags(32'h00000873, "R8 system rd");
    all_flags(32'h0000000f, "R8 fence");
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w;
      w = $urandom;
      if (i % 3 == 0) w[6:0] = 7'b0110011 ^ {4'b0, 3'(i)};
      check(w, i[0], i[1], "R9 random");
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule